// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives a serial audio stream as a clock slave and turns it into parallel samples for a downstream processing unit. A bit clock, a word clock and three serial data lines arrive from an external source. All of them are sampled by a single system clock through a short synchronizer. Each data line carries two channels, so up to six channels are decoded in parallel. The three lines share one framing controller and have a shift path each.

A two-bit format input selects the framing: left-justified, right-justified, the common inter-IC sound format with a one-bit delay, or a frame-pulse format with packed words. A two-bit length input selects 16, 20 or 24 bits for the justified formats. Every word is sign-extended to 24 bits. All six outputs change together, in the single cycle in which a one-cycle valid pulse is raised. Format and length are taken only at frame boundaries, so a change on these inputs never breaks a word that is being received.

The controller has five states:
- **ST_IDLE** waits for the first bit-clock edge after reset.
- **ST_SEEK** waits for a word-clock transition, or for a frame pulse in the packed format. It reloads the configuration while it waits.
- **ST_HALF** receives justified or one-bit-delay half-frames.
- **ST_DSP_LEFT** receives the first packed word.
- **ST_DSP_RIGHT** receives the second packed word.

The transitions are:
- ST_IDLE to ST_SEEK on any bit edge.
- ST_SEEK to ST_HALF on a word-clock change.
- ST_SEEK to ST_DSP_LEFT on a frame pulse.
- ST_HALF to ST_SEEK at a frame end where the requested configuration differs from the latched one.
- ST_DSP_LEFT to ST_DSP_RIGHT after the 16th bit.
- ST_DSP_RIGHT to ST_SEEK after the 16th bit.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after it is released, valid_o is low and samples_o is all zero until the first complete frame is received.
- R2: Data and word clock are taken only on rising edges of the bit clock, after synchronization to clk. Activity on the word clock and data lines while the bit clock is held still produces no valid pulse and leaves samples_o unchanged.
- R3: Format code 0 (left-justified), word length code 0/1/2 = 16/20/24 bits (code 3 = 24). The word clock is high for the left channel. The MSB is the first bit after a word-clock change. Bits after the word length are ignored.
- R4: Format code 1 (right-justified), same length codes as R3. The word clock is high for the left channel. The LSB is the last bit before the next word-clock change. Earlier padding bits are ignored.
- R5: Format code 2 (one-bit delay). The word clock is low for the left channel. The MSB is on the second bit after a word-clock change. The length is always 24 bits and wlen_i is ignored.
- R6: Format code 3 (frame pulse). The word clock is high for exactly one bit as a frame pulse. The left word begins MSB-first on the next bit. 16 left bits are followed directly by 16 right bits. wlen_i is ignored.
- R7: Line k (sdata_i[k]) carries output channel 2k as its left word and channel 2k+1 as its right word. Channel c occupies samples_o[24c+23:24c].
- R8: Every received word is sign-extended from its word length to 24 bits.
- R9: valid_o is a one-cycle pulse, raised once per frame after both words on all lines are complete. samples_o changes only in a cycle in which valid_o is high. A right word with no preceding left word in the same frame is not published.
- R10: Format and length are latched only at a frame boundary. A change during a frame leaves that frame decoded with the old settings. After a change, the receiver resynchronizes and publishes the following complete frames in the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous to clk) |
| wclk_i | input | 1 | Word clock / frame pulse |
| sdata_i | input | NLANES | Serial data lines |
| fmt_i | input | 2 | Framing format code |
| wlen_i | input | 2 | Word length code |
| samples_o | output | 2*NLANES*SW | Sign-extended channel samples, channel c at bits [SW*c +: SW] |
| valid_o | output | 1 | One-cycle pulse when a new frame of samples is presented |

## Verification
At the end of a justified frame, the right-word capture and publication fall on the same bit edge as the reload of the format and length. When the reload differs, the exit to ST_SEEK falls there as well. The bench changes fmt_i and wlen_i halfway through a left-justified 24-bit frame. It then expects that frame to be published intact under the old rules and the next frame to be dropped during resynchronization. Two later frames must be published in right-justified 16-bit form, and no other valid pulse may appear.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = 6;
    localparam int DSP_BITS = 16;
    localparam int I2S_BITS = 24;

    typedef enum logic [1:0] {
        FMT_LEFT_J  = 2'd0,
        FMT_RIGHT_J = 2'd1,
        FMT_I2S     = 2'd2,
        FMT_DSP     = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SEEK      = 3'd1,
        ST_HALF      = 3'd2,
        ST_DSP_LEFT  = 3'd3,
        ST_DSP_RIGHT = 3'd4
    } rx_state_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [1:0] wlen;
    } rx_cfg_t;

    // Per-bit commands from the framing controller to every lane
    typedef struct packed {
        logic shift;     // append the current bit
        logic load1;     // restart the word with the current bit
        logic clr;       // empty the shift register
        logic cap;       // capture a finished word
        logic cap_incl;  // captured word includes the current bit
        logic cap_left;  // captured word is the left channel
        logic publish;   // move both words to the outputs
    } lane_ctl_t;

    function automatic logic [CNT_W-1:0] word_bits(input fmt_e f, input logic [1:0] wl);
        logic [CNT_W-1:0] n;
        unique case (f)
            FMT_I2S: n = CNT_W'(I2S_BITS);
            FMT_DSP: n = CNT_W'(DSP_BITS);
            default: begin
                unique case (wl)
                    2'd0:    n = CNT_W'(16);
                    2'd1:    n = CNT_W'(20);
                    default: n = CNT_W'(24);
                endcase
            end
        endcase
        return n;
    endfunction

    // Lane command used when a new half-frame word begins
    function automatic lane_ctl_t start_ctl(input fmt_e f);
        lane_ctl_t c;
        c = '0;
        unique case (f)
            FMT_LEFT_J: c.load1 = 1'b1;
            FMT_I2S:    c.clr   = 1'b1;
            default:    c.shift = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sarx_sync_edge.sv
module sarx_sync_edge #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic         rise_o
);

    logic [W-1:0] chain_q [STAGES];
    logic         prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= '0;
        end else begin
            chain_q[0] <= async_i;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[s] <= '0;
            end else begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

    // Delayed copy of the synchronized bit clock (bit 0)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_o[0];
        end
    end

    assign rise_o = sync_o[0] & ~prev_q;

endmodule

// File: rtl/sarx_frame_ctrl.sv
module sarx_frame_ctrl
    import sarx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_ev,
    input  logic             wclk_s,
    input  logic [1:0]       fmt_i,
    input  logic [1:0]       wlen_i,
    output lane_ctl_t        ctl_o,
    output logic [CNT_W-1:0] nbits_o,
    output rx_state_e        state_o,
    output logic             valid_o
);

    rx_state_e        state_q, state_d;
    rx_cfg_t          cfg_q, cfg_in;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nb;
    logic             w_last_q;
    logic             got_left_q;
    logic             chg, pulse, under, half_left, frame_end, dsp_last, cfg_diff;

    always_comb begin
        cfg_in.fmt  = fmt_e'(fmt_i);
        cfg_in.wlen = wlen_i;
    end

    assign nb        = word_bits(cfg_q.fmt, cfg_q.wlen);
    assign nbits_o   = nb;
    assign chg       = bit_ev & (wclk_s ^ w_last_q);
    assign pulse     = bit_ev & wclk_s & ~w_last_q;
    assign under     = cnt_q < nb;
    assign half_left = (cfg_q.fmt == FMT_I2S) ? ~w_last_q : w_last_q;
    assign frame_end = (state_q == ST_HALF) & chg & ~half_left;
    assign dsp_last  = bit_ev & (cnt_q == CNT_W'(DSP_BITS - 1));
    assign cfg_diff  = (cfg_in != cfg_q);
    assign state_o   = state_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_ev) state_d = ST_SEEK;
            end
            ST_SEEK: begin
                if (cfg_q.fmt == FMT_DSP) begin
                    if (pulse) state_d = ST_DSP_LEFT;
                end else if (chg) begin
                    state_d = ST_HALF;
                end
            end
            ST_HALF: begin
                if (frame_end && cfg_diff) state_d = ST_SEEK;
            end
            ST_DSP_LEFT: begin
                if (dsp_last) state_d = ST_DSP_RIGHT;
            end
            ST_DSP_RIGHT: begin
                if (dsp_last) state_d = ST_SEEK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Lane commands
    always_comb begin
        ctl_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                ctl_o = '0;
            end
            ST_SEEK: begin
                if (cfg_q.fmt == FMT_DSP) begin
                    ctl_o.clr = pulse;
                end else if (chg) begin
                    ctl_o = start_ctl(cfg_q.fmt);
                end
            end
            ST_HALF: begin
                if (chg) begin
                    ctl_o          = start_ctl(cfg_q.fmt);
                    ctl_o.cap      = 1'b1;
                    ctl_o.cap_incl = (cfg_q.fmt == FMT_I2S) & under;
                    ctl_o.cap_left = half_left;
                    ctl_o.publish  = ~half_left & got_left_q;
                end else if (bit_ev) begin
                    ctl_o.shift = (cfg_q.fmt == FMT_RIGHT_J) | under;
                end
            end
            ST_DSP_LEFT, ST_DSP_RIGHT: begin
                if (dsp_last) begin
                    ctl_o.cap      = 1'b1;
                    ctl_o.cap_incl = 1'b1;
                    ctl_o.cap_left = (state_q == ST_DSP_LEFT);
                    ctl_o.clr      = 1'b1;
                    ctl_o.publish  = (state_q == ST_DSP_RIGHT);
                end else if (bit_ev) begin
                    ctl_o.shift = 1'b1;
                end
            end
            default: ctl_o = '0;
        endcase
    end

    // Frame bookkeeping: bit count, last word-clock level, latched configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            w_last_q   <= 1'b0;
            got_left_q <= 1'b0;
            cfg_q      <= '{fmt: FMT_LEFT_J, wlen: 2'd0};
            valid_o    <= 1'b0;
        end else begin
            valid_o <= ctl_o.publish;
            if (bit_ev) w_last_q <= wclk_s;
            unique case (state_q)
                ST_IDLE, ST_SEEK: begin
                    got_left_q <= 1'b0;
                    if (state_q == ST_SEEK && (chg || pulse)) begin
                        cnt_q <= (cfg_q.fmt == FMT_LEFT_J) ? CNT_W'(1) : '0;
                    end else begin
                        cfg_q <= cfg_in;
                    end
                end
                ST_HALF: begin
                    if (chg) begin
                        cnt_q      <= (cfg_q.fmt == FMT_LEFT_J) ? CNT_W'(1) : '0;
                        got_left_q <= half_left;
                        if (frame_end) cfg_q <= cfg_in;
                    end else if (bit_ev && under) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_DSP_LEFT, ST_DSP_RIGHT: begin
                    if (bit_ev) cnt_q <= dsp_last ? '0 : cnt_q + CNT_W'(1);
                end
                default: cnt_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/sarx_lane.sv
module sarx_lane
    import sarx_pkg::*;
#(
    parameter int SW = SAMPLE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d,
    input  lane_ctl_t        ctl,
    input  logic [CNT_W-1:0] nbits,
    output logic [SW-1:0]    left_o,
    output logic [SW-1:0]    right_o
);

    logic [SW-1:0] sh_q;
    logic [SW-1:0] raw;
    logic [SW-1:0] ext;
    logic [SW-1:0] stage_l_q;
    logic          sgn;

    assign raw = ctl.cap_incl ? {sh_q[SW-2:0], d} : sh_q;

    // Keep the low nbits, extend the sign bit above them
    always_comb begin
        sgn = 1'b0;
        for (int i = 0; i < SW; i++) begin
            if (i == 32'(nbits) - 1) sgn = raw[i];
        end
        for (int i = 0; i < SW; i++) begin
            ext[i] = (i < 32'(nbits)) ? raw[i] : sgn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (ctl.clr) begin
            sh_q <= '0;
        end else if (ctl.load1) begin
            sh_q <= {{(SW-1){1'b0}}, d};
        end else if (ctl.shift) begin
            sh_q <= {sh_q[SW-2:0], d};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_l_q <= '0;
            left_o    <= '0;
            right_o   <= '0;
        end else begin
            if (ctl.cap && ctl.cap_left) stage_l_q <= ext;
            if (ctl.publish) begin
                left_o  <= stage_l_q;
                right_o <= ext;
            end
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int NLANES      = 3,
    parameter int SW          = SAMPLE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bclk_i,
    input  logic                     wclk_i,
    input  logic [NLANES-1:0]        sdata_i,
    input  logic [1:0]               fmt_i,
    input  logic [1:0]               wlen_i,
    output logic [2*NLANES*SW-1:0]   samples_o,
    output logic                     valid_o
);

    localparam int SYNC_W = NLANES + 2;

    logic [SYNC_W-1:0] sync_q;
    logic              bit_rise;
    lane_ctl_t         lane_ctl;
    logic [CNT_W-1:0]  nbits;
    rx_state_e         ctrl_state;

    sarx_sync_edge #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdata_i, wclk_i, bclk_i}),
        .sync_o  (sync_q),
        .rise_o  (bit_rise)
    );

    sarx_frame_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_ev  (bit_rise),
        .wclk_s  (sync_q[1]),
        .fmt_i   (fmt_i),
        .wlen_i  (wlen_i),
        .ctl_o   (lane_ctl),
        .nbits_o (nbits),
        .state_o (ctrl_state),
        .valid_o (valid_o)
    );

    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        sarx_lane #(
            .SW (SW)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .d       (sync_q[2+k]),
            .ctl     (lane_ctl),
            .nbits   (nbits),
            .left_o  (samples_o[(2*k)*SW +: SW]),
            .right_o (samples_o[(2*k+1)*SW +: SW])
        );
    end

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker
    import sarx_pkg::*;
#(
    parameter int OUT_W = 144
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_rise,
    input rx_state_e        state,
    input logic             valid_o,
    input logic [OUT_W-1:0] samples_o
);

    // R1: reset holds the valid strobe low
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !valid_o);

    // R2: a publication always follows a synchronized bit-clock rising edge
    a_r2_valid_after_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(bit_rise));

    // R9: the strobe lasts a single cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9: outputs change only together with the strobe
    a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(samples_o));

    // R10: publication only from a frame-receiving state, never while resynchronizing
    a_r10_publish_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(state) == ST_HALF || $past(state) == ST_DSP_RIGHT));

endmodule

bind serial_audio_rx sarx_checker #(
    .OUT_W (2*NLANES*SW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_rise  (bit_rise),
    .state     (ctrl_state),
    .valid_o   (valid_o),
    .samples_o (samples_o)
);

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;

    localparam int NL = 3;
    localparam int SW = 24;
    localparam int OW = 2*NL*SW;
    localparam int HB = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bclk = 1'b0;
    logic          wclk = 1'b0;
    logic [NL-1:0] sdata = '0;
    logic [1:0]    fmt = 2'd0;
    logic [1:0]    wlen = 2'd0;
    logic [OW-1:0] samples;
    logic          valid;

    int checks = 0;
    int fails  = 0;

    logic [23:0] words [6];
    logic [OW-1:0] got_q [$];
    logic [OW-1:0] exp_q [$];

    serial_audio_rx u_serial_audio_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk),
        .wclk_i    (wclk),
        .sdata_i   (sdata),
        .fmt_i     (fmt),
        .wlen_i    (wlen),
        .samples_o (samples),
        .valid_o   (valid)
    );

    always #10ns clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && valid) got_q.push_back(samples);
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] sx(input logic [23:0] w, input int n);
        logic [23:0] r;
        for (int i = 0; i < 24; i++) r[i] = (i < n) ? w[i] : w[n-1];
        return r;
    endfunction

    function automatic logic [OW-1:0] exp_vec(input int n);
        logic [OW-1:0] v;
        for (int c = 0; c < 6; c++) v[c*SW +: SW] = sx(words[c], n);
        return v;
    endfunction

    task automatic new_words(input int k);
        for (int c = 0; c < 6; c++)
            words[c] = 24'h9A5C31 ^ (24'(c) * 24'h131313) ^ (24'(k) * 24'h2F1E2D);
    endtask

    task automatic tick(input logic w, input logic [NL-1:0] d);
        @(negedge clk);
        bclk = 1'b0; wclk = w; sdata = d;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic apply_reset(input logic [1:0] f, input logic [1:0] wl);
        fmt = f; wlen = wl;
        rst_n = 1'b0; bclk = 1'b0; wclk = 1'b0; sdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        got_q.delete(); exp_q.delete();
    endtask

    function automatic logic jbit(input int f, input int n, input int i, input logic [23:0] w);
        if (f == 0) return (i < n) ? w[n-1-i] : 1'b1;
        if (f == 1) return (i >= HB-n) ? w[HB-1-i] : 1'b1;
        return (i >= 1 && i <= 24) ? w[24-i] : 1'b0;
    endfunction

    task automatic send_half(input int f, input int n, input logic w, input int side);
        for (int i = 0; i < HB; i++) begin
            logic [NL-1:0] d;
            for (int k = 0; k < NL; k++) d[k] = jbit(f, n, i, words[2*k+side]);
            tick(w, d);
        end
    endtask

    task automatic idle_ticks(input logic w, input int cnt);
        for (int i = 0; i < cnt; i++) tick(w, '0);
    endtask

    task automatic compare_frames(input string req);
        repeat (20) @(negedge clk);
        chk(req, "R9 frame count", 32'(got_q.size()), 32'(exp_q.size()));
        for (int f = 0; f < exp_q.size() && f < got_q.size(); f++)
            for (int c = 0; c < 6; c++)
                chk(req, $sformatf("R7 R8 frame %0d ch%0d", f, c),
                    32'(got_q[f][c*SW +: SW]), 32'(exp_q[f][c*SW +: SW]));
        got_q.delete(); exp_q.delete();
    endtask

    // R1
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "valid in reset", 32'(valid), 32'd0);
        chk("R1", "samples in reset", 32'(|samples), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "valid after reset", 32'(valid), 32'd0);
        chk("R1", "samples after reset", 32'(|samples), 32'd0);
    endtask

    // R2: no bit-clock edges, no effect
    task automatic t_bclk_still();
        apply_reset(2'd0, 2'd2);
        bclk = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            wclk = ~wclk; sdata = NL'(i);
            repeat (3) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk("R2", "frames without bit clock", 32'(got_q.size()), 32'd0);
        chk("R2", "samples without bit clock", 32'(|samples), 32'd0);
    endtask

    // R3, R4, R5 (f = 0, 1, 2)
    task automatic t_justified(input int f, input logic [1:0] wl, input string req);
        int n;
        logic lv;
        n  = (f == 2) ? 24 : (wl == 2'd0 ? 16 : (wl == 2'd1 ? 20 : 24));
        lv = (f == 2) ? 1'b0 : 1'b1;
        apply_reset(2'(f), wl);
        idle_ticks(~lv, 4);
        for (int k = 0; k < 2; k++) begin
            new_words(k + 3*f + int'(wl));
            send_half(f, n, lv, 0);
            send_half(f, n, ~lv, 1);
            exp_q.push_back(exp_vec(n));
        end
        idle_ticks(lv, HB);
        compare_frames(req);
    endtask

    // R6
    task automatic t_dsp();
        apply_reset(2'd3, 2'd2);
        idle_ticks(1'b0, 4);
        for (int k = 0; k < 3; k++) begin
            new_words(20 + k);
            tick(1'b1, '0);
            for (int side = 0; side < 2; side++)
                for (int j = 0; j < 16; j++) begin
                    logic [NL-1:0] d;
                    for (int l = 0; l < NL; l++) d[l] = words[2*l+side][15-j];
                    tick(1'b0, d);
                end
            exp_q.push_back(exp_vec(16));
            idle_ticks(1'b0, 7);
        end
        compare_frames("R6");
    endtask

    // R10: change mid-frame from left-justified 24 to right-justified 16
    task automatic t_fmt_switch();
        apply_reset(2'd0, 2'd2);
        idle_ticks(1'b0, 4);
        new_words(30);
        send_half(0, 24, 1'b1, 0);
        fmt = 2'd1; wlen = 2'd0;
        send_half(0, 24, 1'b0, 1);
        exp_q.push_back(exp_vec(24));
        new_words(31);
        send_half(1, 16, 1'b1, 0);
        send_half(1, 16, 1'b0, 1);
        for (int k = 32; k < 34; k++) begin
            new_words(k);
            send_half(1, 16, 1'b1, 0);
            send_half(1, 16, 1'b0, 1);
            exp_q.push_back(exp_vec(16));
        end
        idle_ticks(1'b1, HB);
        compare_frames("R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_bclk_still();
        t_justified(0, 2'd0, "R3");
        t_justified(0, 2'd1, "R3");
        t_justified(0, 2'd2, "R3");
        t_justified(1, 2'd0, "R4");
        t_justified(1, 2'd1, "R4");
        t_justified(1, 2'd3, "R4");
        t_justified(2, 2'd0, "R5");
        t_dsp();
        t_fmt_switch();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule